// File: doc/BRIEF.md
# Four-Phase Command Mailbox Target

This block sits on a simple register port and lets a host processor send single commands to a test engine through a four-phase request/acknowledge exchange. The host places a 32-bit command word in the command register. The word carries an 8-bit opcode in bits 7:0, a request flag in bit 15 and a 12-bit argument in bits 27:16. The host then polls the status register. There, bit 15 is the acknowledge flag, bit 14 is the busy flag and bits 31:16 hold the response data.

A command starts when the mailbox first sees the request flag set. The mailbox stays busy for a fixed number of cycles and then acts on the command. Depending on the opcode it sets a control level, fires a one-cycle strobe or captures a response from the engine's status inputs. It then raises acknowledge. The host clears the request by writing the same word with bit 15 at 0. The mailbox drops acknowledge only after it has seen that clear, and the next command can follow.

The engine itself is outside the block. The block exposes the following toward it:
- loopback enable, pattern code, error-counter setup and inject count, all held as levels;
- start, stop and inject strobes;
- a channel-position flag, a 2-bit test state and a 32-bit error count, all as inputs.

Top module: `mbx_target`

## Requirements
- R1: After reset the status register reads 0, and every control level and strobe output is 0.
- R2: After a command is written with bit 15 = 1 while idle, status bit 14 (busy) reads 1 for exactly EXEC_CYCLES cycles. Status bit 15 (acknowledge) then rises, with busy at 0.
- R3: Acknowledge stays at 1 for as long as the stored request flag is 1. It falls in the cycle after the mailbox sees a command write with bit 15 = 0.
- R4: Writing a command again with bit 15 still at 1, while the mailbox is busy or acknowledging, does not execute it again. No strobe fires and the response does not change.
- R5: The response in status bits 31:16 holds stable while acknowledge is 1, even if the engine inputs change. It reads 0 once acknowledge has fallen.
- R6: Opcode 0x40 sets loopback enable to 1 when the argument is nonzero and to 0 when it is zero. Opcode 0x41 loads the argument into the pattern code, opcode 0x45 into the counter setup and opcode 0x42 into the inject count. Each of these returns a response of 0.
- R7: Opcode 0x0F with argument 0x020 fires the start strobe, with 0x021 the stop strobe and with 0x023 the inject strobe. The strobe lasts one cycle, starting in the cycle acknowledge rises. At most one strobe is high at a time.
- R8: Opcode 0x0D returns the channel-position flag in status bit 16, with all other response bits 0.
- R9: Opcode 0x49 returns the 2-bit test state in status bits 25:24, with all other response bits 0.
- R10: Opcode 0x4A returns error-count bits 11:0 in status bits 27:16. Opcode 0x4B returns bits 27:12 in status bits 31:16. Opcode 0x4C returns bits 31:28 in status bits 19:16. All unused response bits read 0.
- R11: Any other opcode, and opcode 0x0F with any other argument, is still acknowledged. It returns a response of 0, fires no strobe and leaves every control level unchanged.
- R12: Busy and acknowledge are never 1 together, and status bits 13:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 = command, 1 = status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| chan_local0 | input | 1 | Engine: channel sits at local position 0 |
| eng_state | input | 2 | Engine: test state |
| err_count | input | 32 | Engine: accumulated error count |
| loop_en | output | 1 | Loopback enable level |
| pat_code | output | 12 | Selected pattern code |
| cnt_cfg | output | 12 | Error-counter setup value |
| inj_cnt | output | 12 | Number of errors to inject |
| start_pulse | output | 1 | One-cycle start strobe |
| stop_pulse | output | 1 | One-cycle stop strobe |
| inject_pulse | output | 1 | One-cycle inject strobe |

## Verification
The assertions watch, on every cycle, the invariants of the handshake:
- busy and acknowledge are never high together;
- acknowledge cannot drop while the request is still set;
- the response stays frozen across acknowledge;
- strobes appear only on the rise of acknowledge, and one at a time.

Only the bench's scenarios can show that each opcode maps to the right field and slice, and that the busy window has the right length. They also show that a repeated request write leaves the outputs unchanged, and that unknown opcodes leave the control levels untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int OP_W   = 8;
    localparam int ARG_W  = 12;
    localparam int RESP_W = 16;

    localparam int REQ_BIT  = 15;
    localparam int BUSY_BIT = 14;
    localparam int ARG_LSB  = 16;

    localparam logic [OP_W-1:0] OP_PMA_STAT = 8'h0D;
    localparam logic [OP_W-1:0] OP_CTRL     = 8'h0F;
    localparam logic [OP_W-1:0] OP_LOOP     = 8'h40;
    localparam logic [OP_W-1:0] OP_PATTERN  = 8'h41;
    localparam logic [OP_W-1:0] OP_INJ_CNT  = 8'h42;
    localparam logic [OP_W-1:0] OP_CNT_SET  = 8'h45;
    localparam logic [OP_W-1:0] OP_TST_STAT = 8'h49;
    localparam logic [OP_W-1:0] OP_ERR_LO   = 8'h4A;
    localparam logic [OP_W-1:0] OP_ERR_MID  = 8'h4B;
    localparam logic [OP_W-1:0] OP_ERR_HI   = 8'h4C;

    localparam logic [ARG_W-1:0] CTRL_START  = 12'h020;
    localparam logic [ARG_W-1:0] CTRL_STOP   = 12'h021;
    localparam logic [ARG_W-1:0] CTRL_INJECT = 12'h023;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_BUSY = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } mbx_cmd_t;

    typedef struct packed {
        logic loop_wr;
        logic pat_wr;
        logic inj_wr;
        logic cnt_wr;
        logic start;
        logic stop;
        logic inject;
    } mbx_act_t;

    function automatic mbx_act_t decode_act(input mbx_cmd_t c);
        mbx_act_t a;
        a = '0;
        unique case (c.op)
            OP_LOOP:    a.loop_wr = 1'b1;
            OP_PATTERN: a.pat_wr  = 1'b1;
            OP_INJ_CNT: a.inj_wr  = 1'b1;
            OP_CNT_SET: a.cnt_wr  = 1'b1;
            OP_CTRL: begin
                a.start  = (c.arg == CTRL_START);
                a.stop   = (c.arg == CTRL_STOP);
                a.inject = (c.arg == CTRL_INJECT);
            end
            default: a = '0;
        endcase
        return a;
    endfunction

    function automatic mbx_cmd_t word_to_cmd(input logic [31:0] w);
        mbx_cmd_t c;
        c.op  = w[OP_W-1:0];
        c.arg = w[ARG_LSB +: ARG_W];
        return c;
    endfunction

endpackage

// File: rtl/mbx_cmd_regs.sv
module mbx_cmd_regs
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CMD_ADDR  = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       status_word,
    output logic [31:0]       bus_rdata,
    output logic              req,
    output mbx_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic [31:0] cmd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word <= '0;
        end else if (bus_wr && bus_addr == CMD_A) begin
            cmd_word <= bus_wdata;
        end
    end

    always_comb begin
        if (bus_addr == CMD_A) begin
            bus_rdata = cmd_word;
        end else if (bus_addr == STAT_A) begin
            bus_rdata = status_word;
        end else begin
            bus_rdata = '0;
        end
    end

    assign req = cmd_word[REQ_BIT];
    assign cmd = word_to_cmd(cmd_word);

endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake
    import mbx_pkg::*;
#(
    parameter int EXEC_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  mbx_cmd_t cmd_in,
    output logic     busy,
    output logic     ack,
    output logic     fire,
    output logic     release_rsp,
    output mbx_cmd_t cmd_exec
);

    localparam int CNT_W = (EXEC_CYCLES < 2) ? 1 : $clog2(EXEC_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EXEC_CYCLES - 1);

    hs_state_e  state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_IDLE;
            cnt      <= '0;
            cmd_exec <= '0;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (req) begin
                        state    <= HS_BUSY;
                        cnt      <= '0;
                        cmd_exec <= cmd_in;
                    end
                end
                HS_BUSY: begin
                    if (cnt == LAST) begin
                        state <= HS_ACK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                HS_ACK: begin
                    if (!req) begin
                        state <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign busy        = (state == HS_BUSY);
    assign ack         = (state == HS_ACK);
    assign fire        = busy && (cnt == LAST);
    assign release_rsp = ack && !req;

endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              release_rsp,
    input  mbx_cmd_t          cmd_exec,
    input  logic              chan_local0,
    input  logic [1:0]        eng_state,
    input  logic [31:0]       err_count,
    output logic [RESP_W-1:0] resp_q,
    output logic              loop_en,
    output logic [ARG_W-1:0]  pat_code,
    output logic [ARG_W-1:0]  cnt_cfg,
    output logic [ARG_W-1:0]  inj_cnt,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              inject_pulse
);

    logic [RESP_W-1:0] resp_next;
    mbx_act_t          act;

    assign act = decode_act(cmd_exec);

    always_comb begin
        unique case (cmd_exec.op)
            OP_PMA_STAT: resp_next = {{(RESP_W-1){1'b0}}, chan_local0};
            OP_TST_STAT: resp_next = {6'b0, eng_state, 8'b0};
            OP_ERR_LO:   resp_next = {4'b0, err_count[11:0]};
            OP_ERR_MID:  resp_next = err_count[27:12];
            OP_ERR_HI:   resp_next = {12'b0, err_count[31:28]};
            default:     resp_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q       <= '0;
            loop_en      <= 1'b0;
            pat_code     <= '0;
            cnt_cfg      <= '0;
            inj_cnt      <= '0;
            start_pulse  <= 1'b0;
            stop_pulse   <= 1'b0;
            inject_pulse <= 1'b0;
        end else begin
            start_pulse  <= 1'b0;
            stop_pulse   <= 1'b0;
            inject_pulse <= 1'b0;
            if (fire) begin
                resp_q       <= resp_next;
                start_pulse  <= act.start;
                stop_pulse   <= act.stop;
                inject_pulse <= act.inject;
                if (act.loop_wr) loop_en  <= |cmd_exec.arg;
                if (act.pat_wr)  pat_code <= cmd_exec.arg;
                if (act.cnt_wr)  cnt_cfg  <= cmd_exec.arg;
                if (act.inj_wr)  inj_cnt  <= cmd_exec.arg;
            end else if (release_rsp) begin
                resp_q <= '0;
            end
        end
    end

endmodule

// File: rtl/mbx_target.sv
module mbx_target
    import mbx_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int EXEC_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              chan_local0,
    input  logic [1:0]        eng_state,
    input  logic [31:0]       err_count,
    output logic              loop_en,
    output logic [11:0]       pat_code,
    output logic [11:0]       cnt_cfg,
    output logic [11:0]       inj_cnt,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              inject_pulse
);

    logic              req;
    logic              busy;
    logic              ack;
    logic              fire;
    logic              release_rsp;
    mbx_cmd_t          cmd;
    mbx_cmd_t          cmd_exec;
    logic [RESP_W-1:0] resp_q;
    logic [31:0]       status_word;

    assign status_word = {resp_q, ack, busy, {BUSY_BIT{1'b0}}};

    mbx_cmd_regs #(
        .ADDR_W    (ADDR_W),
        .CMD_ADDR  (0),
        .STAT_ADDR (1)
    ) regs_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .status_word (status_word),
        .bus_rdata   (bus_rdata),
        .req         (req),
        .cmd         (cmd)
    );

    mbx_handshake #(
        .EXEC_CYCLES (EXEC_CYCLES)
    ) hs_i (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .cmd_in      (cmd),
        .busy        (busy),
        .ack         (ack),
        .fire        (fire),
        .release_rsp (release_rsp),
        .cmd_exec    (cmd_exec)
    );

    mbx_exec exec_i (
        .clk          (clk),
        .rst          (rst),
        .fire         (fire),
        .release_rsp  (release_rsp),
        .cmd_exec     (cmd_exec),
        .chan_local0  (chan_local0),
        .eng_state    (eng_state),
        .err_count    (err_count),
        .resp_q       (resp_q),
        .loop_en      (loop_en),
        .pat_code     (pat_code),
        .cnt_cfg      (cnt_cfg),
        .inj_cnt      (inj_cnt),
        .start_pulse  (start_pulse),
        .stop_pulse   (stop_pulse),
        .inject_pulse (inject_pulse)
    );

endmodule

// File: rtl/mbx_target_chk.sv
module mbx_target_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        ack,
    input logic        req,
    input logic [15:0] resp_q,
    input logic        start_pulse,
    input logic        stop_pulse,
    input logic        inject_pulse
);

    // R12
    busy_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && ack));

    // R2
    ack_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(busy));

    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && req) |=> ack);

    // R3
    ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req));

    // R5
    resp_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> $stable(resp_q));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_pulse, stop_pulse, inject_pulse}));

    // R4
    strobe_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start_pulse || stop_pulse || inject_pulse) |-> $rose(ack));

endmodule

bind mbx_target mbx_target_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .ack          (ack),
    .req          (req),
    .resp_q       (resp_q),
    .start_pulse  (start_pulse),
    .stop_pulse   (stop_pulse),
    .inject_pulse (inject_pulse)
);

// File: tb/mbx_target_tb_top.sv
module mbx_target_tb_top;

    localparam int ADDR_W = 2;
    localparam int EXEC   = 4;

    typedef struct {
        logic [15:0] resp;
        logic [2:0]  pul;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = 2'd1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        chan_local0 = 1'b0;
    logic [1:0]  eng_state = 2'b00;
    logic [31:0] err_count = '0;
    logic        loop_en;
    logic [11:0] pat_code, cnt_cfg, inj_cnt;
    logic        start_pulse, stop_pulse, inject_pulse;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    mbx_target #(.ADDR_W(ADDR_W), .EXEC_CYCLES(EXEC)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_local0(chan_local0), .eng_state(eng_state), .err_count(err_count),
        .loop_en(loop_en), .pat_code(pat_code), .cnt_cfg(cnt_cfg), .inj_cnt(inj_cnt),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .inject_pulse(inject_pulse)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected responses on every rise of acknowledge
    initial begin
        logic prev_ack;
        prev_ack = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            if (start_pulse || stop_pulse || inject_pulse) pulse_cnt++;
            if (bus_addr == 2'd1) begin
                if (bus_rdata[15] && !prev_ack) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected ack", bus_rdata, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(bus_rdata[31:16] == e.resp, "R8/R9/R10/R11 response",
                            {16'b0, bus_rdata[31:16]}, {16'b0, e.resp});
                        chk({start_pulse, stop_pulse, inject_pulse} == e.pul, "R7 strobes",
                            {29'b0, start_pulse, stop_pulse, inject_pulse}, {29'b0, e.pul});
                    end
                end
                prev_ack = bus_rdata[15];
            end
        end
    end

    task automatic bus_write(input logic [31:0] w);
        bus_wr    = 1'b1;
        bus_addr  = 2'd0;
        bus_wdata = w;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 2'd1;
    endtask

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [11:0] arg, input bit rq);
        return {4'b0, arg, rq, 7'b0, op};
    endfunction

    task automatic wait_ack(output int busy_n, output bit got);
        busy_n = 0;
        got = 1'b0;
        for (int i = 0; i < 100 && !got; i++) begin
            @(negedge clk);
            if (bus_rdata[14]) busy_n++;
            if (bus_rdata[15]) got = 1'b1;
            chk(bus_rdata[13:0] == 14'b0 && !(bus_rdata[14] && bus_rdata[15]),
                "R12 status", bus_rdata, {bus_rdata[31:16], 16'b0});
        end
    endtask

    task automatic release_cmd(input logic [7:0] op, input logic [11:0] arg);
        bit low;
        bus_write(mk(op, arg, 1'b0));
        low = 1'b0;
        for (int i = 0; i < 100 && !low; i++) begin
            @(negedge clk);
            if (!bus_rdata[15]) low = 1'b1;
        end
        chk(low, "R3 ack fall", {31'b0, low}, 1);
        chk(bus_rdata[31:16] == 16'h0, "R5 response cleared", bus_rdata, 0);
    endtask

    task automatic issue(input logic [7:0] op, input logic [11:0] arg,
                         input logic [15:0] eresp, input logic [2:0] epul);
        int  bn;
        bit  got;
        exp_q.push_back('{resp: eresp, pul: epul});
        bus_write(mk(op, arg, 1'b1));
        wait_ack(bn, got);
        chk(got && bn == EXEC, "R2 busy window", bn, EXEC);
        release_cmd(op, arg);
    endtask

    initial begin
        int  bn;
        bit  got;
        int  pc;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_rdata == 32'h0, "R1 status", bus_rdata, 0);
        chk({loop_en, pat_code, cnt_cfg, inj_cnt, start_pulse, stop_pulse, inject_pulse} == '0,
            "R1 outputs", {31'b0, loop_en}, 0);

        // R6 control levels
        issue(8'h40, 12'h006, 16'h0, 3'b000);
        chk(loop_en == 1'b1, "R6 loopback", {31'b0, loop_en}, 1);
        issue(8'h41, 12'h30C, 16'h0, 3'b000);
        chk(pat_code == 12'h30C, "R6 pattern", {20'b0, pat_code}, 32'h30C);
        issue(8'h45, 12'h014, 16'h0, 3'b000);
        chk(cnt_cfg == 12'h014, "R6 counter setup", {20'b0, cnt_cfg}, 32'h14);
        issue(8'h42, 12'h123, 16'h0, 3'b000);
        chk(inj_cnt == 12'h123, "R6 inject count", {20'b0, inj_cnt}, 32'h123);

        // R8 channel position
        chan_local0 = 1'b1;
        issue(8'h0D, 12'h000, 16'h0001, 3'b000);
        chan_local0 = 1'b0;
        issue(8'h0D, 12'h000, 16'h0000, 3'b000);

        // R7 strobes
        issue(8'h0F, 12'h020, 16'h0, 3'b100);
        issue(8'h0F, 12'h023, 16'h0, 3'b001);
        issue(8'h0F, 12'h021, 16'h0, 3'b010);

        // R9 test state
        eng_state = 2'b01;
        issue(8'h49, 12'h000, 16'h0100, 3'b000);
        eng_state = 2'b11;
        issue(8'h49, 12'h000, 16'h0300, 3'b000);

        // R10 error-count slices
        err_count = 32'hABCD_E123;
        issue(8'h4A, 12'h000, 16'h0123, 3'b000);
        issue(8'h4B, 12'h000, 16'hBCDE, 3'b000);
        issue(8'h4C, 12'h000, 16'h000A, 3'b000);

        // R11 unknown opcode and unknown control argument
        pc = pulse_cnt;
        issue(8'h55, 12'hFFF, 16'h0, 3'b000);
        issue(8'h0F, 12'h7FF, 16'h0, 3'b000);
        chk(pulse_cnt == pc, "R11 no strobe", pulse_cnt, pc);
        chk(loop_en && pat_code == 12'h30C && cnt_cfg == 12'h014 && inj_cnt == 12'h123,
            "R11 levels unchanged", {20'b0, pat_code}, 32'h30C);

        // R6 loopback disable with zero argument
        issue(8'h40, 12'h000, 16'h0, 3'b000);
        chk(loop_en == 1'b0, "R6 loopback off", {31'b0, loop_en}, 0);

        // R4 / R5 rewrite with request held, engine inputs change
        err_count = 32'h0000_0456;
        exp_q.push_back('{resp: 16'h0456, pul: 3'b000});
        bus_write(mk(8'h4A, 12'h000, 1'b1));
        wait_ack(bn, got);
        chk(got && bn == EXEC, "R2 busy window", bn, EXEC);
        held = bus_rdata;
        pc = pulse_cnt;
        err_count = 32'h0000_0789;
        bus_write(mk(8'h0F, 12'h020, 1'b1));
        repeat (8) @(negedge clk);
        chk(bus_rdata[15] == 1'b1, "R3 ack held", bus_rdata, held);
        chk(bus_rdata[31:16] == held[31:16], "R5 response stable", bus_rdata, held);
        chk(pulse_cnt == pc, "R4 no re-execution", pulse_cnt, pc);
        chk(exp_q.size() == 0, "R4 no extra ack", exp_q.size(), 0);
        release_cmd(8'h0F, 12'h020);
        repeat (6) @(negedge clk);
        chk(pulse_cnt == pc && bus_rdata[15:14] == 2'b00, "R4 idle after release",
            pulse_cnt, pc);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule